// File: doc/BRIEF.md
# RTC Interrupt Flag and Alarm Unit

This unit collects the three interrupt sources of a real-time clock and drives a single active-low interrupt request. A periodic tick from the divider sets the periodic flag. An update-end strobe from the time-keeping logic sets the update flag. On that same strobe, the freshly updated seconds, minutes and hours bytes are compared against three programmable alarm bytes, and a full match sets the alarm flag. Every flag latches whether or not its enable is set. The request output is the OR of each flag gated by its own enable.

Software programs the alarm bytes and the three enables through a small register port. It reads one status byte that holds the summary request bit and the three flags. Reading that byte returns its contents, and the flags are cleared one edge later. A flag event that lands on the clearing edge is kept rather than lost. Any alarm byte whose two most significant bits are both 1 matches every value of its time byte. A rising edge on the time-set mode input forces the update interrupt enable off.

Top module: `rtc_irq_alarm`

## Requirements
- R1: After reset, the status byte (address 4) reads 0x00, the control byte (address 3) reads 0x00, the alarm bytes read 0x00 and irq_n_o is 1.
- R2: A one-cycle tick_i pulse sets the periodic flag (status bit 6) even when the periodic enable (control bit 0) is 0. In that case irq_n_o stays 1.
- R3: A one-cycle upd_end_i pulse sets the update flag (status bit 4).
- R4: On an upd_end_i pulse where seconds, minutes and hours (tm_i bytes 0, 1, 2) all equal alarm bytes at addresses 0, 1 and 2, the alarm flag (status bit 5) is set.
- R5: An alarm byte with bits 7:6 equal to 2'b11 matches any value of its time byte. The other alarm bytes still have to match exactly.
- R6: The request bit (status bit 7) equals PF·PIE + AF·AIE + UF·UIE, with the enables at control bits 0, 1 and 2. irq_n_o is 0 exactly when that bit is 1.
- R7: The status byte is read-only. A write to address 4 changes nothing, and status bits 3:0 always read 0.
- R8: A read with reg_re_i at address 4 returns the current status. On the next edge it clears all three flags, which releases irq_n_o.
- R9: A tick_i or upd_end_i event on the same edge as a status-clearing read leaves its flag set.
- R10: A 0-to-1 transition of set_mode_i clears the update enable. This clear also overrides a control write on the same edge. A level that stays high does not block later writes.
- R11: The alarm flag is set only by upd_end_i. A tick_i with matching time bytes leaves it clear, and so does an upd_end_i with any byte mismatched.
- R12: The control byte reads back {5'b0, UIE, AIE, PIE}. Written bits 7:3 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Periodic tick, one cycle per event |
| upd_end_i | input | 1 | Update-end strobe; tm_i is valid with it |
| set_mode_i | input | 1 | Time-set mode level |
| tm_i | input | 24 | Time bytes: [7:0] seconds, [15:8] minutes, [23:16] hours |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (status read clears flags) |
| reg_addr_i | input | 3 | Register address: 0..2 alarms, 3 control, 4 status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from reg_addr_i |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a flag event that lands on exactly the edge where a status read clears the flags. The result hinges on set-over-clear priority inside one cycle. The bench drives tick_i and the clearing read on the same falling edge. It then checks both the value returned by that read and the flag state after the edge. The second hard case is a rising edge on set_mode_i that coincides with a control write. The bench provokes it by raising the level in the same cycle as the write.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   localparam int unsigned N_FIELDS = 3;   // seconds, minutes, hours
   localparam int unsigned N_SRC    = 3;   // periodic, alarm, update
   // source index, shared by flag and enable vectors
   localparam int unsigned SRC_PF = 0;
   localparam int unsigned SRC_AF = 1;
   localparam int unsigned SRC_UF = 2;
   // register addresses
   localparam int unsigned ADR_ALM0 = 0;
   localparam int unsigned ADR_CTRL = 3;
   localparam int unsigned ADR_STAT = 4;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] alarm_i,
   input  logic [DATA_W-1:0] time_i,
   output logic              hit_o
);
   localparam logic [1:0] WILD = 2'b11;

   logic wild;
   assign wild  = (alarm_i[DATA_W-1 -: 2] == WILD);
   assign hit_o = wild || (alarm_i == time_i);
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] flag_o
);
   for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_o[g] <= 1'b0;
         else if (set_i[g]) flag_o[g] <= 1'b1;   // new event beats clear
         else if (clr_i)    flag_o[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
   import rtc_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_i,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [DATA_W-1:0]                wdata_i,
   input  logic                             set_mode_i,
   output logic [N_FIELDS-1:0][DATA_W-1:0]  alarm_o,
   output logic [N_SRC-1:0]                 en_o
);
   logic set_q;
   logic set_rise;
   logic ctrl_wr;

   assign set_rise = set_mode_i && !set_q;
   assign ctrl_wr  = we_i && (addr_i == ADDR_W'(ADR_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) set_q <= 1'b0;
      else        set_q <= set_mode_i;
   end

   for (genvar g = 0; g < N_FIELDS; g++) begin : g_alm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            alarm_o[g] <= '0;
         else if (we_i && (addr_i == ADDR_W'(ADR_ALM0 + g)))
            alarm_o[g] <= wdata_i;
      end
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_en
      if (s == SRC_UF) begin : g_uie
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        en_o[s] <= 1'b0;
            else if (set_rise) en_o[s] <= 1'b0;
            else if (ctrl_wr)  en_o[s] <= wdata_i[s];
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       en_o[s] <= 1'b0;
            else if (ctrl_wr) en_o[s] <= wdata_i[s];
         end
      end
   end
endmodule

// File: rtl/rtc_irq_alarm.sv
module rtc_irq_alarm
   import rtc_irq_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 3,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick_i,
   input  logic                         upd_end_i,
   input  logic                         set_mode_i,
   input  logic [N_FIELDS*DATA_W-1:0]   tm_i,
   input  logic                         reg_we_i,
   input  logic                         reg_re_i,
   input  logic [ADDR_W-1:0]            reg_addr_i,
   input  logic [DATA_W-1:0]            reg_wdata_i,
   output logic [DATA_W-1:0]            reg_rdata_o,
   output logic                         irq_n_o
);
   localparam int unsigned LOW_W = DATA_W - 4;

   if (DATA_W < 5) begin : g_chk_w
      $error("rtc_irq_alarm: DATA_W must be at least 5");
   end
   if ((1 << ADDR_W) <= ADR_STAT) begin : g_chk_a
      $error("rtc_irq_alarm: ADDR_W too narrow for register map");
   end

   logic [N_FIELDS-1:0][DATA_W-1:0] alarm_q;
   logic [N_SRC-1:0]                en_q;
   logic [N_SRC-1:0]                flag_q;
   logic [N_SRC-1:0]                flag_set;
   logic [N_FIELDS-1:0]             field_hit;
   logic                            alarm_hit;
   logic                            stat_clr;
   logic                            irqf;
   logic [DATA_W-1:0]               stat_word;
   logic [DATA_W-1:0]               ctrl_word;

   rtc_ctrl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (reg_we_i),
      .addr_i     (reg_addr_i),
      .wdata_i    (reg_wdata_i),
      .set_mode_i (set_mode_i),
      .alarm_o    (alarm_q),
      .en_o       (en_q)
   );

   for (genvar g = 0; g < N_FIELDS; g++) begin : g_cmp
      rtc_alarm_cmp #(.DATA_W(DATA_W)) u_cmp (
         .alarm_i (alarm_q[g]),
         .time_i  (tm_i[g*DATA_W +: DATA_W]),
         .hit_o   (field_hit[g])
      );
   end

   assign alarm_hit = &field_hit;

   always_comb begin
      flag_set         = '0;
      flag_set[SRC_PF] = tick_i;
      flag_set[SRC_AF] = upd_end_i && alarm_hit;
      flag_set[SRC_UF] = upd_end_i;
   end

   assign stat_clr = reg_re_i && (reg_addr_i == ADDR_W'(ADR_STAT));

   rtc_flag_bank #(.N(N_SRC)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set),
      .clr_i  (stat_clr),
      .flag_o (flag_q)
   );

   assign irqf = |(flag_q & en_q);

   // status: request, periodic, alarm, update in the top four bits
   assign stat_word = {irqf, flag_q[SRC_PF], flag_q[SRC_AF], flag_q[SRC_UF],
                       {LOW_W{1'b0}}};
   assign ctrl_word = {{(DATA_W-N_SRC){1'b0}}, en_q};

   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i == ADDR_W'(ADR_STAT))
         reg_rdata_o = stat_word;
      else if (reg_addr_i == ADDR_W'(ADR_CTRL))
         reg_rdata_o = ctrl_word;
      else begin
         for (int f = 0; f < N_FIELDS; f++)
            if (reg_addr_i == ADDR_W'(ADR_ALM0 + f))
               reg_rdata_o = alarm_q[f];
      end
   end

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b1;
         else        irq_q <= !irqf;
      end
      assign irq_n_o = irq_q;
   end else begin : g_irq_comb
      assign irq_n_o = !irqf;
   end
endmodule

// File: rtl/rtc_irq_alarm_chk.sv
module rtc_irq_alarm_chk
   import rtc_irq_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 3,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              upd_end_i,
   input logic              set_mode_i,
   input logic              reg_re_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              irq_n_o,
   input logic [N_SRC-1:0]  flag_q,
   input logic [N_SRC-1:0]  en_q
);
   logic at_stat;
   assign at_stat = (reg_addr_i == ADDR_W'(ADR_STAT));

   AST_PF_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> flag_q[SRC_PF]);                                        // R2
   AST_UF_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      upd_end_i |=> flag_q[SRC_UF]);                                     // R3
   AST_AF_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[SRC_AF]) |-> $past(upd_end_i));                       // R11
   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      at_stat |-> (reg_rdata_o[DATA_W-5:0] == '0));                      // R7
   AST_RDCLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re_i && at_stat && !tick_i && !upd_end_i) |=> (flag_q == '0)); // R8
   AST_RACE_KEEPS_PF: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re_i && at_stat && tick_i) |=> flag_q[SRC_PF]);               // R9
   AST_SET_RISE_UIE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(set_mode_i) |=> !en_q[SRC_UF]);                              // R10

   if (!IRQ_REG) begin : g_comb
      AST_IRQ_VS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
         at_stat |-> (reg_rdata_o[DATA_W-1] == !irq_n_o));               // R6
   end
endmodule

bind rtc_irq_alarm rtc_irq_alarm_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_i     (tick_i),
   .upd_end_i  (upd_end_i),
   .set_mode_i (set_mode_i),
   .reg_re_i   (reg_re_i),
   .reg_addr_i (reg_addr_i),
   .reg_rdata_o(reg_rdata_o),
   .irq_n_o    (irq_n_o),
   .flag_q     (flag_q),
   .en_q       (en_q)
);

// File: tb/rtc_irq_alarm_tb_top.sv
module rtc_irq_alarm_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        upd = 1'b0;
   logic        setm = 1'b0;
   logic [23:0] tm = '0;
   logic        we = 1'b0;
   logic        re = 1'b0;
   logic [2:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq_n;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;   // 50 MHz

   rtc_irq_alarm dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .upd_end_i(upd),
      .set_mode_i(setm), .tm_i(tm), .reg_we_i(we), .reg_re_i(re),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .irq_n_o(irq_n)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; re = 1'b0;
      #1 d = rdata;
   endtask

   task automatic rd_clr(output logic [7:0] d);
      @(negedge clk);
      addr = 3'd4; re = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      re = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic pulse_upd(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      @(negedge clk); tm = {h, m, s}; upd = 1'b1;
      @(negedge clk); upd = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      peek(3'd4, v); chk("R1 status", v, 8'h00);
      peek(3'd3, v); chk("R1 ctrl", v, 8'h00);
      peek(3'd0, v); chk("R1 alarm", v, 8'h00);
      chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
   endtask

   task automatic t_periodic();
      logic [7:0] v;
      pulse_tick();
      peek(3'd4, v); chk("R2 pf w/o pie", v, 8'h40);
      chk("R2 irq_n idle", {7'b0, irq_n}, 8'h01);
      wr(3'd3, 8'h01);
      peek(3'd4, v); chk("R6 pf&pie", v, 8'hC0);
      chk("R6 irq_n low", {7'b0, irq_n}, 8'h00);
      rd_clr(v); chk("R8 read value", v, 8'hC0);
      peek(3'd4, v); chk("R8 cleared", v, 8'h00);
      chk("R8 irq released", {7'b0, irq_n}, 8'h01);
      wr(3'd3, 8'h00);
   endtask

   task automatic t_update();
      logic [7:0] v;
      wr(3'd3, 8'h04);
      pulse_upd(8'h12, 8'h34, 8'h56);
      peek(3'd4, v); chk("R3 uf, R11 no af", v, 8'h90);
      chk("R3 irq_n", {7'b0, irq_n}, 8'h00);
      rd_clr(v);
      wr(3'd3, 8'h00);
   endtask

   task automatic t_alarm();
      logic [7:0] v;
      wr(3'd0, 8'h30); wr(3'd1, 8'h15); wr(3'd2, 8'h08);
      wr(3'd3, 8'h02);
      @(negedge clk); tm = {8'h08, 8'h15, 8'h30};
      pulse_tick();
      peek(3'd4, v); chk("R11 tick no af", v, 8'h40);
      rd_clr(v);
      pulse_upd(8'h08, 8'h15, 8'h30);
      peek(3'd4, v); chk("R4 full match", v, 8'hB0);
      chk("R4 irq_n", {7'b0, irq_n}, 8'h00);
      rd_clr(v);
      pulse_upd(8'h09, 8'h15, 8'h30);
      peek(3'd4, v); chk("R11 hour mismatch", v, 8'h10);
      rd_clr(v);
   endtask

   task automatic t_dontcare();
      logic [7:0] v;
      wr(3'd2, 8'hC0); wr(3'd1, 8'hFF); wr(3'd0, 8'h30);
      pulse_upd(8'h17, 8'h42, 8'h30);
      peek(3'd4, v); chk("R5 wildcard match", v, 8'hB0);
      rd_clr(v);
      pulse_upd(8'h17, 8'h42, 8'h31);
      peek(3'd4, v); chk("R5 exact sec mismatch", v, 8'h10);
      rd_clr(v);
      wr(3'd3, 8'h00);
   endtask

   task automatic t_status_wr();
      logic [7:0] v;
      pulse_tick();
      wr(3'd4, 8'hFF);
      peek(3'd4, v); chk("R7 write ignored", v, 8'h40);
      wr(3'd4, 8'h00);
      peek(3'd4, v); chk("R7 still set", v, 8'h40);
      rd_clr(v);
   endtask

   task automatic t_race();
      logic [7:0] v;
      @(negedge clk);
      addr = 3'd4; re = 1'b1; tick = 1'b1;
      #1 v = rdata;
      chk("R9 read before event", v, 8'h00);
      @(negedge clk);
      re = 1'b0; tick = 1'b0;
      peek(3'd4, v); chk("R9 pf kept", v, 8'h40);
      rd_clr(v);
   endtask

   task automatic t_set();
      logic [7:0] v;
      wr(3'd3, 8'h04);
      peek(3'd3, v); chk("R12 uie readback", v, 8'h04);
      @(negedge clk); setm = 1'b1;
      peek(3'd3, v); chk("R10 rise clears uie", v, 8'h00);
      wr(3'd3, 8'h04);
      peek(3'd3, v); chk("R10 level no block", v, 8'h04);
      @(negedge clk); setm = 1'b0;
      @(negedge clk);
      setm = 1'b1; we = 1'b1; addr = 3'd3; wdata = 8'h07;
      @(negedge clk); we = 1'b0;
      peek(3'd3, v); chk("R10 rise beats write", v, 8'h03);
      @(negedge clk); setm = 1'b0;
   endtask

   task automatic t_ctrl();
      logic [7:0] v;
      wr(3'd3, 8'hFF);
      peek(3'd3, v); chk("R12 upper dropped", v, 8'h07);
      wr(3'd3, 8'h01);
      pulse_upd(8'h00, 8'h00, 8'h00);
      peek(3'd4, v); chk("R6 uf without uie", v, 8'h10);
      chk("R6 irq idle", {7'b0, irq_n}, 8'h01);
      pulse_tick();
      peek(3'd4, v); chk("R6 or of sources", v, 8'hD0);
      chk("R6 irq low", {7'b0, irq_n}, 8'h00);
      rd_clr(v);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_periodic();
      t_update();
      t_alarm();
      t_dontcare();
      t_status_wr();
      t_race();
      t_set();
      t_ctrl();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule